// File: doc/BRIEF.md
# Morse Code Letter Transmitter

This block plays the Morse pattern of one of eight letters (A to H) on two lamp outputs. A 3-bit select input names the letter. When a start pulse arrives while the block is idle, it looks up the letter's symbols. The symbols go into a 4-bit shift register, and the number of symbols goes into a size counter. The block then plays the symbols one at a time. A dot lights one output and a dash lights the other. Each symbol is held for one timing period, and a dark period of the same length separates consecutive symbols.

The timing period is a parameter counted in clock cycles. In silicon it is set to one second of clock cycles; a bench sets it to a few cycles. A busy output is high for the whole transmission. A start pulse that arrives during a transmission has no effect.

Top module: `morse_tx`

## Requirements
- R1: Select value 0 to 7 names letter A to H. The patterns are: A = dot dash, B = dash dot dot dot, C = dash dot dash dot, D = dash dot dot, E = dot, F = dot dot dash dot, G = dash dash dot, H = dot dot dot dot.
- R2: When start is sampled high at a rising edge while idle, the first symbol appears on the outputs in the cycle that follows that edge.
- R3: A load writes the letter's symbols into a 4-bit register, first symbol in bit 0, with 1 = dash and 0 = dot. The same load writes the symbol count (1 to 4) into the size counter.
- R4: Each shift moves the register right by one place, puts a 0 into bit 3, and decrements the size counter by one.
- R5: During a symbol, `dot_o` is high for a dot and `dash_o` is high for a dash. Each symbol lasts exactly PERIOD_CYCLES clock cycles, and the two outputs are never high together.
- R6: Between two symbols of a letter, both outputs are low for exactly PERIOD_CYCLES cycles.
- R7: `busy_o` is high from the cycle after the load until the last symbol ends. When the size counter reaches zero, the block returns to idle, drops `busy_o` and sends no trailing gap.
- R8: A start pulse or a select change that occurs while `busy_o` is high has no effect on the transmission in progress.
- R9: A low `rst_n` sampled at a rising edge returns the block to idle. The outputs go low, and both the register and the size counter are cleared.
- R10: The period counter never exceeds PERIOD_CYCLES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the rising edge |
| letter_i | input | 3 | Letter select, 0 = A through 7 = H |
| dot_o | output | 1 | High while a dot is shown |
| dash_o | output | 1 | High while a dash is shown |
| busy_o | output | 1 | High while a transmission is in progress |

## Verification
The assertions assume that `start_i` and `letter_i` are clean synchronous levels. They also assume that reset is held low for at least one edge before the block is used. The bench drives every input on the falling clock edge, so each input is stable when the design samples it. The bench sends all eight letters and compares each output cycle against a pattern it builds from the letter's dot-dash text. It repeats the sends with start pulses and select changes injected during a transmission, and with a reset applied part-way through a letter.

// File: rtl/morse_pkg.sv
// Package: shared state type and letter lookup for the Morse transmitter.
// Assumes letters are stored first-symbol-in-bit-0, 1 = dash, 0 = dot.
package morse_pkg;

    localparam int SYM_BITS = 4;
    localparam int SIZE_W   = $clog2(SYM_BITS + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MARK = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_t;

    typedef struct packed {
        logic [SYM_BITS-1:0] bits;
        logic [SIZE_W-1:0]   len;
    } letter_t;

    // Map a 3-bit select to the letter's symbol bits and count.
    function automatic letter_t letter_lookup(input logic [2:0] sel);
        letter_t r;
        case (sel)
            3'd0:    begin r.bits = 4'b0010; r.len = 3'd2; end // A
            3'd1:    begin r.bits = 4'b0001; r.len = 3'd4; end // B
            3'd2:    begin r.bits = 4'b0101; r.len = 3'd4; end // C
            3'd3:    begin r.bits = 4'b0001; r.len = 3'd3; end // D
            3'd4:    begin r.bits = 4'b0000; r.len = 3'd1; end // E
            3'd5:    begin r.bits = 4'b0100; r.len = 3'd4; end // F
            3'd6:    begin r.bits = 4'b0011; r.len = 3'd3; end // G
            default: begin r.bits = 4'b0000; r.len = 3'd4; end // H
        endcase
        return r;
    endfunction

endpackage

// File: rtl/morse_lookup.sv
// Module: morse_lookup
// Combinational letter table. It turns the select into symbol bits and a symbol count.
// Assumes: select is a stable synchronous level.
module morse_lookup
    import morse_pkg::*;
(
    input  logic [2:0]          sel_i,
    output logic [SYM_BITS-1:0] bits_o,
    output logic [SIZE_W-1:0]   len_o
);
    letter_t entry;

    // Purpose: decode the select through the package table.
    always_comb begin
        entry  = letter_lookup(sel_i);
        bits_o = entry.bits;
        len_o  = entry.len;
    end
endmodule

// File: rtl/morse_tick.sv
// Module: morse_tick
// Period timer. It counts clock cycles while run is high and gives a one-cycle
// tick on the last cycle of each period. It holds at zero while run is low.
// Assumes: PERIOD_CYCLES >= 2.
module morse_tick #(
    parameter int PERIOD_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    // Purpose: advance the period counter, wrapping at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run_i || tick_o) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R10
endmodule

// File: rtl/morse_symreg.sv
// Module: morse_symreg
// Symbol store: a shift register holding the remaining symbols and a size
// counter holding how many are left. Load has priority over shift.
// Assumes: shift is only requested while size is non-zero.
module morse_symreg
    import morse_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                shift_i,
    input  logic [SYM_BITS-1:0] bits_i,
    input  logic [SIZE_W-1:0]   len_i,
    output logic [SYM_BITS-1:0] data_o,
    output logic [SIZE_W-1:0]   size_o
);
    logic [SYM_BITS-1:0] data_q;
    logic [SIZE_W-1:0]   size_q;

    // Purpose: load a new letter or step to the next symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            size_q <= '0;
        end else if (load_i) begin
            data_q <= bits_i;
            size_q <= len_i;
        end else if (shift_i) begin
            data_q <= {1'b0, data_q[SYM_BITS-1:1]};
            size_q <= size_q - 1'b1;
        end
    end

    assign data_o = data_q;
    assign size_o = size_q;

    AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (size_q == $past(len_i)) && (data_q == $past(bits_i))); // R3
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> !data_q[SYM_BITS-1]); // R4
    AST_SIZE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> size_q == $past(size_q) - 1'b1); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> size_q != '0); // R7
endmodule

// File: rtl/morse_tx.sv
// Module: morse_tx (top)
// Morse letter transmitter. On a start pulse while idle it loads the letter.
// It then alternates mark and gap periods until the size counter empties.
// Assumes: inputs are synchronous to clk; PERIOD_CYCLES >= 2.
module morse_tx
    import morse_pkg::*;
#(
    parameter int PERIOD_CYCLES = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] letter_i,
    output logic       dot_o,
    output logic       dash_o,
    output logic       busy_o
);
    tx_state_t           state_q, state_d;
    logic                load, shift, tick, run;
    logic [SYM_BITS-1:0] lk_bits, data;
    logic [SIZE_W-1:0]   lk_len, size;

    morse_lookup u_lookup (
        .sel_i  (letter_i),
        .bits_o (lk_bits),
        .len_o  (lk_len)
    );

    morse_tick #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    morse_symreg u_symreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .bits_i  (lk_bits),
        .len_i   (lk_len),
        .data_o  (data),
        .size_o  (size)
    );

    // Purpose: derive control strobes and the next state.
    always_comb begin
        run     = (state_q != ST_IDLE);
        load    = (state_q == ST_IDLE) && start_i;
        shift   = (state_q == ST_MARK) && tick;
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start_i) state_d = ST_MARK;
            ST_MARK: if (tick)    state_d = (size == SIZE_W'(1)) ? ST_IDLE : ST_GAP;
            ST_GAP:  if (tick)    state_d = ST_MARK;
            default:              state_d = ST_IDLE;
        endcase
    end

    // Purpose: hold the transmit state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: drive the lamps from the current symbol.
    assign dot_o  = (state_q == ST_MARK) && !data[0];
    assign dash_o = (state_q == ST_MARK) &&  data[0];
    assign busy_o = run;

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !shift) |=> $stable(data) && $stable(size)); // R8
    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && size == SIZE_W'(1)) |=> !busy_o && size == '0); // R7
    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !dot_o && !dash_o); // R9
    AST_FIRST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (dot_o || dash_o)); // R2
endmodule

// File: tb/tb_morse_tx.sv
// Bench: sends every letter in turn, with and without start or select changes
// injected mid-letter, and once with a reset during a letter. Every cycle is
// compared with a pattern built from the letter's dot-dash text.
module tb_morse_tx;
    localparam int P = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] letter_i = 3'd0;
    logic       dot_o, dash_o, busy_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    morse_tx #(.PERIOD_CYCLES(P)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .letter_i(letter_i),
        .dot_o(dot_o), .dash_o(dash_o), .busy_o(busy_o)
    );

    function automatic string pattern(input int sel); // R1
        case (sel)
            0: return ".-";
            1: return "-...";
            2: return "-.-.";
            3: return "-..";
            4: return ".";
            5: return "..-.";
            6: return "--.";
            default: return "....";
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s at %0t: got dot/dash/busy=%b expected %b", req, $time, got, exp);
        end
    endtask

    // Send one letter. mode 0: clean. mode 1: inject a start pulse and a select change mid-letter.
    task automatic send(input int sel, input int mode);
        string s = pattern(sel);
        int n = s.len();
        int total = (2 * n - 1) * P;
        @(negedge clk);
        letter_i = 3'(sel);
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        for (int i = 0; i < total; i++) begin
            int slot = i / P;
            logic [2:0] exp;
            if (slot % 2 == 1) exp = 3'b001;                       // R6 gap
            else if (s[slot / 2] == "-") exp = 3'b011;             // R5 dash
            else exp = 3'b101;                                     // R5 dot
            check((i == 0) ? "R2" : ((slot % 2) ? "R6" : "R5"), {dot_o, dash_o, busy_o}, exp);
            if (mode == 1 && i == 1) begin
                start_i  = 1'b1;                                   // R8
                letter_i = 3'(7 - sel);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R7", {dot_o, dash_o, busy_o}, 3'b000);              // R7 no trailing gap
        @(negedge clk);
        check("R7", {dot_o, dash_o, busy_o}, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", {dot_o, dash_o, busy_o}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {dot_o, dash_o, busy_o}, 3'b000);
        for (int m = 0; m < 2; m++)
            for (int sel = 0; sel < 8; sel++) send(sel, m);
        // Reset during a letter (R9), then confirm a clean restart.
        @(negedge clk);
        letter_i = 3'd1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (P + 1) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", {dot_o, dash_o, busy_o}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {dot_o, dash_o, busy_o}, 3'b000);
        send(4, 0);
        send(2, 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: run did not complete");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule